// File: doc/BRIEF.md
# Signed halfword multiply-accumulate unit

This block is the execute stage for a family of signed multiply instructions that work on 16-bit halves of 32-bit operands. It decodes an instruction word and recognises five forms. Three are 16x16 forms: a multiply, a multiply-accumulate into 32 bits, and a multiply-accumulate into a 64-bit pair. The other two are 32x16 forms: a multiply that keeps the upper 32 bits of the 48-bit product, and a multiply-accumulate built on that shifted product.

The block sends out the register indices that the surrounding register file must read. It takes back the two multiplicands and the low and high accumulator words. It returns one or two destination writes and a request to set the sticky overflow flag. The 32-bit accumulates wrap on overflow but still request the flag. The 64-bit accumulate never requests it. The register file and the status register live outside the block.

A parameter selects the output timing. With the registered variant (the default), results appear one cycle after `in_valid`. With the combinational variant, they appear in the same cycle. A second parameter chooses between one shared 48-bit multiplier and two separate multipliers.

Top module: `hmac_unit`

## Requirements
- R1: A word with (w & 0x0ff00090) == 0x01000080 is the 16x16 accumulate. Destination 0 has index w[19:16] and receives (half product + acc_lo) modulo 2^32.
- R2: In the 16x16 forms, w[5]=1 selects op_a[31:16] and w[5]=0 selects op_a[15:0]. In the same way, w[6] selects the half of op_b. Each selected half is read as a signed 16-bit value.
- R3: A word with (w & 0x0ff00090) == 0x01400080 is the 64-bit accumulate. The 64-bit sum is {acc_hi, acc_lo} plus the sign-extended 32-bit half product. Destination 0 has index w[15:12] and receives the low word of the sum. Destination 1 has index w[19:16] and receives the high word. The overflow flag is never requested for this form.
- R4: A word with (w & 0x0ff00090) == 0x01600080 is the 16x16 multiply. Destination 0 has index w[19:16] and receives the 32-bit product. No flag is requested.
- R5: A word with (w & 0x0ff000b0) == 0x012000a0 is the 32x16 multiply. Destination 0 has index w[19:16] and receives bits [47:16] of the signed product of op_a and the op_b half chosen by w[6]. No flag is requested.
- R6: A word with (w & 0x0ff000b0) == 0x01200080 is the 32x16 accumulate. Destination 0 has index w[19:16] and receives (R5 result + acc_lo) modulo 2^32.
- R7: For the R1 and R6 forms, ovf_set is 1 exactly when the accumulate addition overflows as a signed 32-bit sum. The product by itself never causes a flag request.
- R8: rd_a_idx = w[3:0], rd_b_idx = w[11:8], rd_lo_idx = w[15:12] and rd_hi_idx = w[19:16]. These follow instr combinationally.
- R9: A word that matches none of the five forms drives dst0_we, dst1_we and ovf_set low.
- R10: When reset is asserted, every output of the registered stage goes to 0. With the default registered variant, a beat accepted while in_valid=1 appears on the outputs one clock later with out_valid=1. A beat with in_valid=0 raises no write-enable and no flag request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The instruction and operands are valid in this cycle |
| instr | input | 32 | Instruction word |
| op_a | input | 32 | First multiplicand, read from rd_a_idx |
| op_b | input | 32 | Second multiplicand, read from rd_b_idx |
| acc_lo | input | 32 | Accumulator, or the low word of the 64-bit pair, read from rd_lo_idx |
| acc_hi | input | 32 | High word of the 64-bit pair, read from rd_hi_idx |
| rd_a_idx | output | 4 | Register index of the first multiplicand |
| rd_b_idx | output | 4 | Register index of the second multiplicand |
| rd_lo_idx | output | 4 | Register index of the accumulator or low word |
| rd_hi_idx | output | 4 | Register index of the high word |
| out_valid | output | 1 | A result beat is presented |
| dst0_we | output | 1 | Write-enable for destination 0 |
| dst0_idx | output | 4 | Register index of destination 0 |
| dst0_data | output | 32 | Data for destination 0 |
| dst1_we | output | 1 | Write-enable for destination 1 (64-bit form only) |
| dst1_idx | output | 4 | Register index of destination 1 |
| dst1_data | output | 32 | Data for destination 1 |
| ovf_set | output | 1 | Request to set the sticky overflow flag |

## Verification
The bench runs random words for each of the five forms, with random register fields and half-select bits, so that a swapped half or a wrong index field gives a wrong result. Operands are drawn partly from the signed extremes, which exercises the -32768 x -32768 product and the arithmetic shift of negative 48-bit products. Directed accumulates on both sides of the signed 32-bit limit separate a correct wrapping sum with a flag request from a saturating result or a missing flag. A carry from the low word into the high word tells a true 64-bit add from two independent 32-bit adds. Fully random words, near-miss words with one decode bit flipped, and valid forms sent with in_valid low show that nothing is written without a matching, valid beat.

// File: rtl/hmac_pkg.sv
package hmac_pkg;

   localparam int unsigned HM_INSTR_W = 32;
   localparam int unsigned HM_IDX_W   = 4;

   // register field positions inside the instruction word
   localparam int unsigned HM_POS_A   = 0;
   localparam int unsigned HM_POS_B   = 8;
   localparam int unsigned HM_POS_LO  = 12;
   localparam int unsigned HM_POS_HI  = 16;
   localparam int unsigned HM_POS_XA  = 5;
   localparam int unsigned HM_POS_XB  = 6;

   // decode masks and match values
   localparam logic [HM_INSTR_W-1:0] HM_MASK_HH  = 32'h0ff0_0090;
   localparam logic [HM_INSTR_W-1:0] HM_MASK_WH  = 32'h0ff0_00b0;
   localparam logic [HM_INSTR_W-1:0] HM_VAL_MAC  = 32'h0100_0080;
   localparam logic [HM_INSTR_W-1:0] HM_VAL_MACL = 32'h0140_0080;
   localparam logic [HM_INSTR_W-1:0] HM_VAL_MUL  = 32'h0160_0080;
   localparam logic [HM_INSTR_W-1:0] HM_VAL_MULW = 32'h0120_00a0;
   localparam logic [HM_INSTR_W-1:0] HM_VAL_MACW = 32'h0120_0080;

   typedef enum logic [2:0] {
      HM_NONE,
      HM_MAC16,
      HM_MACL16,
      HM_MUL16,
      HM_MULW,
      HM_MACW
   } hm_op_e;

endpackage

// File: rtl/hmac_decode.sv
module hmac_decode
   import hmac_pkg::*;
(
   input  logic [HM_INSTR_W-1:0] instr,
   output hm_op_e                op,
   output logic                  a_top,
   output logic                  b_top,
   output logic [HM_IDX_W-1:0]   idx_a,
   output logic [HM_IDX_W-1:0]   idx_b,
   output logic [HM_IDX_W-1:0]   idx_lo,
   output logic [HM_IDX_W-1:0]   idx_hi
);

   logic [HM_INSTR_W-1:0] hh_bits;
   logic [HM_INSTR_W-1:0] wh_bits;

   assign hh_bits = instr & HM_MASK_HH;
   assign wh_bits = instr & HM_MASK_WH;

   always_comb begin
      op = HM_NONE;
      if (hh_bits == HM_VAL_MAC)
         op = HM_MAC16;
      else if (hh_bits == HM_VAL_MACL)
         op = HM_MACL16;
      else if (hh_bits == HM_VAL_MUL)
         op = HM_MUL16;
      else if (wh_bits == HM_VAL_MULW)
         op = HM_MULW;
      else if (wh_bits == HM_VAL_MACW)
         op = HM_MACW;
   end

   assign a_top  = instr[HM_POS_XA];
   assign b_top  = instr[HM_POS_XB];
   assign idx_a  = instr[HM_POS_A  +: HM_IDX_W];
   assign idx_b  = instr[HM_POS_B  +: HM_IDX_W];
   assign idx_lo = instr[HM_POS_LO +: HM_IDX_W];
   assign idx_hi = instr[HM_POS_HI +: HM_IDX_W];

endmodule

// File: rtl/hmac_halfsel.sv
module hmac_halfsel #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0]          word,
   input  logic                       top,
   output logic signed [DATA_W-1:0]   half_ext
);

   localparam int unsigned HALF_W = DATA_W / 2;

   logic [HALF_W-1:0] half;

   assign half     = top ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];
   assign half_ext = $signed({{HALF_W{half[HALF_W-1]}}, half});

endmodule

// File: rtl/hmac_arith.sv
module hmac_arith
   import hmac_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter bit          SHARE_MULT = 1'b1
) (
   input  hm_op_e             op,
   input  logic               a_top,
   input  logic               b_top,
   input  logic [DATA_W-1:0]  op_a,
   input  logic [DATA_W-1:0]  op_b,
   input  logic [DATA_W-1:0]  acc_lo,
   input  logic [DATA_W-1:0]  acc_hi,
   output logic [DATA_W-1:0]  res0,
   output logic [DATA_W-1:0]  res1,
   output logic               ovf
);

   localparam int unsigned HALF_W = DATA_W / 2;
   localparam int unsigned PROD_W = DATA_W + HALF_W;
   localparam int unsigned LONG_W = 2 * DATA_W;

   logic signed [DATA_W-1:0] a_h;
   logic signed [DATA_W-1:0] b_h;
   logic signed [DATA_W-1:0] p_short;
   logic signed [DATA_W-1:0] p_wide;
   logic                     wide_form;

   hmac_halfsel #(.DATA_W(DATA_W)) i_sel_a (.word(op_a), .top(a_top), .half_ext(a_h));
   hmac_halfsel #(.DATA_W(DATA_W)) i_sel_b (.word(op_b), .top(b_top), .half_ext(b_h));

   assign wide_form = (op == HM_MULW) || (op == HM_MACW);

   generate
      if (SHARE_MULT) begin : g_shared
         // one 48-bit multiplier; the 16x16 forms feed a sign-extended half
         logic signed [PROD_W-1:0] m_a;
         logic signed [PROD_W-1:0] m_b;
         logic signed [PROD_W-1:0] m_p;
         assign m_a = wide_form ? {{HALF_W{op_a[DATA_W-1]}}, op_a}
                                : {{HALF_W{a_h[DATA_W-1]}}, a_h};
         assign m_b = {{HALF_W{b_h[DATA_W-1]}}, b_h};
         assign m_p = m_a * m_b;
         assign p_short = m_p[DATA_W-1:0];
         assign p_wide  = m_p[PROD_W-1:HALF_W];
      end else begin : g_split
         logic signed [PROD_W-1:0] w_a;
         logic signed [PROD_W-1:0] w_b;
         assign w_a     = {{HALF_W{op_a[DATA_W-1]}}, op_a};
         assign w_b     = {{HALF_W{b_h[DATA_W-1]}}, b_h};
         assign p_short = a_h * b_h;
         assign p_wide  = DATA_W'((w_a * w_b) >>> HALF_W);
      end
   endgenerate

   logic [DATA_W-1:0] addend;
   logic [DATA_W:0]   sum_x;
   logic [LONG_W-1:0] sum_l;

   assign addend = (op == HM_MACW) ? p_wide : p_short;
   assign sum_x  = {acc_lo[DATA_W-1], acc_lo} + {addend[DATA_W-1], addend};
   assign sum_l  = {acc_hi, acc_lo} + {{DATA_W{p_short[DATA_W-1]}}, p_short};

   always_comb begin
      res0 = sum_x[DATA_W-1:0];
      ovf  = 1'b0;
      case (op)
         HM_MAC16, HM_MACW: begin
            res0 = sum_x[DATA_W-1:0];
            ovf  = sum_x[DATA_W] ^ sum_x[DATA_W-1];
         end
         HM_MACL16: res0 = sum_l[DATA_W-1:0];
         HM_MUL16:  res0 = p_short;
         HM_MULW:   res0 = p_wide;
         default:   res0 = sum_x[DATA_W-1:0];
      endcase
   end

   assign res1 = sum_l[LONG_W-1:DATA_W];

endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
   import hmac_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter bit          OUT_REG    = 1'b1,
   parameter bit          SHARE_MULT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [31:0]          instr,
   input  logic [DATA_W-1:0]    op_a,
   input  logic [DATA_W-1:0]    op_b,
   input  logic [DATA_W-1:0]    acc_lo,
   input  logic [DATA_W-1:0]    acc_hi,
   output logic [3:0]           rd_a_idx,
   output logic [3:0]           rd_b_idx,
   output logic [3:0]           rd_lo_idx,
   output logic [3:0]           rd_hi_idx,
   output logic                 out_valid,
   output logic                 dst0_we,
   output logic [3:0]           dst0_idx,
   output logic [DATA_W-1:0]    dst0_data,
   output logic                 dst1_we,
   output logic [3:0]           dst1_idx,
   output logic [DATA_W-1:0]    dst1_data,
   output logic                 ovf_set
);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("hmac_unit: the instruction encoding fixes DATA_W at 32");
      end
      if (HM_IDX_W != 4) begin : g_bad_idx
         $error("hmac_unit: register index fields are 4 bits wide");
      end
   endgenerate

   hm_op_e                op;
   logic                  a_top;
   logic                  b_top;
   logic [HM_IDX_W-1:0]   idx_lo;
   logic [HM_IDX_W-1:0]   idx_hi;
   logic [DATA_W-1:0]     res0;
   logic [DATA_W-1:0]     res1;
   logic                  ovf;

   hmac_decode i_decode (
      .instr  (instr),
      .op     (op),
      .a_top  (a_top),
      .b_top  (b_top),
      .idx_a  (rd_a_idx),
      .idx_b  (rd_b_idx),
      .idx_lo (idx_lo),
      .idx_hi (idx_hi)
   );

   assign rd_lo_idx = idx_lo;
   assign rd_hi_idx = idx_hi;

   hmac_arith #(.DATA_W(DATA_W), .SHARE_MULT(SHARE_MULT)) i_arith (
      .op     (op),
      .a_top  (a_top),
      .b_top  (b_top),
      .op_a   (op_a),
      .op_b   (op_b),
      .acc_lo (acc_lo),
      .acc_hi (acc_hi),
      .res0   (res0),
      .res1   (res1),
      .ovf    (ovf)
   );

   // combinational result beat
   logic                  c_we0;
   logic                  c_we1;
   logic                  c_ovf;
   logic [HM_IDX_W-1:0]   c_idx0;

   assign c_we0  = in_valid && (op != HM_NONE);
   assign c_we1  = in_valid && (op == HM_MACL16);
   assign c_ovf  = in_valid && ovf;
   assign c_idx0 = (op == HM_MACL16) ? idx_lo : idx_hi;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               dst0_we   <= 1'b0;
               dst1_we   <= 1'b0;
               ovf_set   <= 1'b0;
               dst0_idx  <= '0;
               dst1_idx  <= '0;
               dst0_data <= '0;
               dst1_data <= '0;
            end else begin
               out_valid <= in_valid;
               dst0_we   <= c_we0;
               dst1_we   <= c_we1;
               ovf_set   <= c_ovf;
               dst0_idx  <= c_idx0;
               dst1_idx  <= idx_hi;
               dst0_data <= res0;
               dst1_data <= res1;
            end
         end

         // R9: an unmatched word leaves the next beat quiet
         assert_undecoded_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op == HM_NONE) |=> (!dst0_we && !dst1_we && !ovf_set));

         // R10: a matched valid beat shows up one clock later
         assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op != HM_NONE) |=> (out_valid && dst0_we));

         // R3: the 64-bit form never asks for the flag
         assert_long_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op == HM_MACL16) |=> (dst1_we && !ovf_set));
      end else begin : g_comb
         assign out_valid = in_valid;
         assign dst0_we   = c_we0;
         assign dst1_we   = c_we1;
         assign ovf_set   = c_ovf;
         assign dst0_idx  = c_idx0;
         assign dst1_idx  = idx_hi;
         assign dst0_data = res0;
         assign dst1_data = res1;

         // R9: an unmatched word raises nothing in the same cycle
         assert_undecoded_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (op == HM_NONE) |-> (!dst0_we && !dst1_we && !ovf_set));
      end
   endgenerate

   // R7: a flag request only ever comes with a single 32-bit write
   assert_flag_single_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set |-> (dst0_we && !dst1_we));

   // R10: nothing is written outside a valid beat
   assert_we_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dst0_we || dst1_we || ovf_set) |-> out_valid);

   // R3: a high-word write always pairs with a low-word write to another field
   assert_pair_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dst1_we |-> dst0_we);

endmodule

// File: tb/test_hmac_unit.sv
module test_hmac_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] instr, op_a, op_b, acc_lo, acc_hi;
   logic [3:0]  rd_a_idx, rd_b_idx, rd_lo_idx, rd_hi_idx;
   logic        out_valid, dst0_we, dst1_we, ovf_set;
   logic [3:0]  dst0_idx, dst1_idx;
   logic [31:0] dst0_data, dst1_data;

   always #5 clk = ~clk;

   hmac_unit i_hmac_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .op_a(op_a), .op_b(op_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
      .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx), .rd_lo_idx(rd_lo_idx), .rd_hi_idx(rd_hi_idx),
      .out_valid(out_valid), .dst0_we(dst0_we), .dst0_idx(dst0_idx), .dst0_data(dst0_data),
      .dst1_we(dst1_we), .dst1_idx(dst1_idx), .dst1_data(dst1_data), .ovf_set(ovf_set)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #1_500_000;
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   // form codes: 0 none, 1 acc16, 2 acc64, 3 mul16, 4 mulw, 5 accw
   function automatic int form_of(logic [31:0] w);
      if ((w & 32'h0ff00090) == 32'h01000080) return 1;
      if ((w & 32'h0ff00090) == 32'h01400080) return 2;
      if ((w & 32'h0ff00090) == 32'h01600080) return 3;
      if ((w & 32'h0ff000b0) == 32'h012000a0) return 4;
      if ((w & 32'h0ff000b0) == 32'h01200080) return 5;
      return 0;
   endfunction

   function automatic logic [31:0] make_instr(int f, logic [31:0] r);
      case (f)
         1: return 32'h01000080 | (r & 32'hf00fff6f);
         2: return 32'h01400080 | (r & 32'hf00fff6f);
         3: return 32'h01600080 | (r & 32'hf00fff6f);
         4: return 32'h012000a0 | (r & 32'hf00fff4f);
         5: return 32'h01200080 | (r & 32'hf00fff4f);
         default: return r;
      endcase
   endfunction

   logic        e_we0, e_we1, e_ovf;
   logic [3:0]  e_idx0, e_idx1;
   logic [31:0] e_d0, e_d1;

   task automatic predict(logic [31:0] w, logic [31:0] a, logic [31:0] b,
                          logic [31:0] lo, logic [31:0] hi, logic v);
      int f;
      logic signed [31:0] ha, hb, p16;
      longint pw, s;
      logic [63:0] u;
      f = form_of(w);
      e_we0 = 1'b0; e_we1 = 1'b0; e_ovf = 1'b0;
      e_idx0 = w[19:16]; e_idx1 = w[19:16]; e_d0 = '0; e_d1 = '0;
      if (!v || f == 0) return;
      ha  = w[5] ? {{16{a[31]}}, a[31:16]} : {{16{a[15]}}, a[15:0]};
      hb  = w[6] ? {{16{b[31]}}, b[31:16]} : {{16{b[15]}}, b[15:0]};
      p16 = ha * hb;
      pw  = (longint'($signed(a)) * longint'(hb)) >>> 16;
      e_we0 = 1'b1;
      case (f)
         1: begin
            s = longint'($signed(lo)) + longint'(p16);
            e_d0 = s[31:0];
            e_ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
         end
         2: begin
            u = {hi, lo} + {{32{p16[31]}}, p16};
            e_idx0 = w[15:12]; e_d0 = u[31:0];
            e_we1 = 1'b1; e_d1 = u[63:32];
         end
         3: e_d0 = p16;
         4: e_d0 = pw[31:0];
         default: begin
            s = longint'($signed(lo)) + longint'($signed(pw[31:0]));
            e_d0 = s[31:0];
            e_ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
         end
      endcase
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(logic [31:0] w, logic [31:0] a, logic [31:0] b,
                       logic [31:0] lo, logic [31:0] hi, logic v, string tag);
      string t;
      int f;
      f = form_of(w);
      instr = w; op_a = a; op_b = b; acc_lo = lo; acc_hi = hi; in_valid = v;
      #1;
      check({rd_a_idx, rd_b_idx, rd_lo_idx, rd_hi_idx} == {w[3:0], w[11:8], w[15:12], w[19:16]},
            "R8", "read indices", {48'd0, rd_a_idx, rd_b_idx, rd_lo_idx, rd_hi_idx},
            {48'd0, w[3:0], w[11:8], w[15:12], w[19:16]});
      predict(w, a, b, lo, hi, v);
      if (tag != "") t = tag;
      else if (!v) t = "R10";
      else case (f)
         0: t = "R9";
         1: t = "R1";
         2: t = "R3";
         3: t = "R4";
         4: t = "R5";
         default: t = "R6";
      endcase
      @(negedge clk);
      check(out_valid == v, "R10", "out_valid", {63'd0, out_valid}, {63'd0, v});
      check({dst0_we, dst1_we} == {e_we0, e_we1}, t, "write enables",
            {62'd0, dst0_we, dst1_we}, {62'd0, e_we0, e_we1});
      check(ovf_set == e_ovf, (f == 2) ? "R3" : "R7", "ovf_set", {63'd0, ovf_set}, {63'd0, e_ovf});
      if (e_we0)
         check({dst0_idx, dst0_data} == {e_idx0, e_d0}, t, "dst0 idx/data",
               {28'd0, dst0_idx, dst0_data}, {28'd0, e_idx0, e_d0});
      if (e_we1)
         check({dst1_idx, dst1_data} == {e_idx1, e_d1}, t, "dst1 idx/data",
               {28'd0, dst1_idx, dst1_data}, {28'd0, e_idx1, e_d1});
   endtask

   function automatic logic [31:0] pick_val();
      case ($urandom % 10)
         0: return 32'h7fff_ffff;
         1: return 32'h8000_0000;
         2: return 32'hffff_ffff;
         3: return 32'h8000_8000;
         4: return 32'h7fff_7fff;
         5: return 32'h0000_0000;
         default: return $urandom;
      endcase
   endfunction

   initial begin
      void'($urandom(32'h5eed_2024));
      rst_n = 1'b0; in_valid = 1'b0;
      instr = '0; op_a = '0; op_b = '0; acc_lo = '0; acc_hi = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check({out_valid, dst0_we, dst1_we, ovf_set, dst0_idx, dst1_idx} == '0 &&
            dst0_data == '0 && dst1_data == '0, "R10", "reset state",
            {out_valid, dst0_we, dst1_we, ovf_set, dst0_idx, dst1_idx, dst0_data[15:0], 28'd0}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      step(32'h0163_0080, 32'h0000_8000, 32'h0000_8000, 0, 0, 1, "R4");     // -32768 squared
      step(32'h016400a1, 32'hfffe_0003, 32'h0000_0005, 0, 0, 1, "R2");      // top of a
      step(32'h016500c2, 32'hfffe_0003, 32'h8000_0000, 0, 0, 1, "R2");      // top of b
      step(32'h016600e3, 32'h8001_7fff, 32'h7fff_8000, 0, 0, 1, "R2");      // both tops
      step(32'h01017080, 32'h0000_0001, 32'h0000_0001, 32'h7fff_ffff, 0, 1, "R7");  // +wrap
      step(32'h01027080, 32'h0000_8000, 32'h0000_7fff, 32'h8000_0000, 0, 1, "R7");  // -wrap
      step(32'h01037080, 32'h0000_0001, 32'h0000_0001, 32'h7fff_fffe, 0, 1, "R7");  // edge, no wrap
      step(32'h01454080, 32'h0000_0001, 32'h0000_0001, 32'hffff_ffff, 0, 1, "R3");  // carry up
      step(32'h01464080, 32'h0000_ffff, 32'h0000_0001, 0, 0, 1, "R3");             // -1 extend
      step(32'h01474080, 32'h0000_0001, 32'h0000_0001, 32'h7fff_ffff, 32'h7fff_ffff, 1, "R3");
      step(32'h012800a0, 32'h8000_0000, 32'h0000_8000, 0, 0, 1, "R5");
      step(32'h012900a0, 32'hffff_ffff, 32'h0000_0001, 0, 0, 1, "R5");      // arith shift
      step(32'h012a00e0, 32'h1234_5678, 32'h8000_0000, 0, 0, 1, "R5");      // bit 6 top
      step(32'h012b2080, 32'h7fff_ffff, 32'h0000_7fff, 32'h7fff_ffff, 0, 1, "R7");  // accw wrap
      step(32'h012c2080, 32'h0001_0000, 32'h0000_0003, 32'h0000_0010, 0, 1, "R6");
      step(32'h01000090, 32'h0000_0001, 32'h0000_0001, 32'h7fff_ffff, 0, 1, "R9");  // bit 4 set
      step(32'h012000b0, 32'h7fff_ffff, 32'h7fff_ffff, 32'h7fff_ffff, 0, 1, "R9");
      step(32'h01a00080, 32'h7fff_ffff, 32'h7fff_ffff, 0, 0, 1, "R9");
      step(32'h01017080, 32'h0000_0001, 32'h0000_0001, 32'h7fff_ffff, 0, 0, "R10"); // not valid

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         int f;
         logic [31:0] w;
         f = $urandom % 6;
         w = make_instr(f, $urandom);
         step(w, pick_val(), pick_val(), pick_val(), pick_val(), ($urandom % 8) != 0, "");
      end

      in_valid = 1'b0;
      summary();
      $finish;
   end

endmodule